// File: doc/BRIEF.md
# Interrupt Status and Holdoff Unit

This unit gathers single-cycle event pulses from the engines of a network adapter into a pending-interrupt register. Software sees that register through two register views. One view returns the pending bits and leaves them in place. The other returns them and clears exactly the bits it returned. An enable register with the same bit layout selects which pending bits may raise the single interrupt output.

A master control register holds the engine enables, the transmit mode select and a 3-bit interrupt select value. Its two lowest bits start timed holdoff windows. While a window runs, the interrupt output is held low. When the window ends, its bit reads back as zero. Both window lengths are parameters counted in clock cycles. At 125 MHz the defaults give 0.5 ms and 1 ms.

Register access uses a simple word-wide port. Read data is combinational while the read strobe is high. A write or a clearing read takes effect at the next rising clock edge.

Top module: `irq_status_ctrl`

## Requirements
- R1: A read at index 0x02 returns the pending status and leaves it unchanged, so a second read returns the same value.
- R2: A read at index 0x01 returns the pending status, and after that clock edge every bit it returned is zero.
- R3: An event that arrives in the same cycle as a clearing read at 0x01 is not returned by that read, and it is pending afterwards.
- R4: Event input bit i sets status bit i. Bits 0 to 8 are statistics, line interface, service list, TX DMA done, RX DMA done, DMA error, DMA length error, identifier mismatch and DMA overflow. Bits 16:9 are transmit channels 0 to 7.
- R5: Index 0x03 is the interrupt enable register. It stores bits 16:0 of the write data and reads them back, with bits 31:17 read as zero.
- R6: With no holdoff running, irq_o is high exactly when some bit is both pending and enabled.
- R7: Index 0x04 is master control. Bits 8:2 read back exactly as written: bit 2 receive enable, bit 3 transmit enable, bit 4 DMA enable, bit 5 lock (1) or streaming (0), and bits 8:6 interrupt select. Bits 31:9 read as zero.
- R8: Writing master control with bit 0 set starts the short holdoff. For HOLD_SHORT_CYC cycles after that write edge, bit 0 reads 1 and irq_o is low. After that, bit 0 reads 0.
- R9: Writing master control with bit 1 set starts the long holdoff for HOLD_LONG_CYC cycles, with the same readback and masking rules as R8.
- R10: A write to index 0x01 or 0x02 changes neither the pending status nor any other register.
- R11: After reset, the status, enable and control registers read 0 and irq_o is low.
- R12: A read at an index other than 0x01 to 0x04 returns 0. Writing master control with a holdoff bit at 0 stops that holdoff.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid while reg_rd is high |
| evt_pulse | input | 9+N_TXCH | Event pulses, one bit per status bit |
| irq_o | output | 1 | Interrupt request |

## Verification
Random traffic mixes sparse multi-bit event pulses with reads and writes to every index, including unmapped ones. This checks both status views, the enable masking and the control readback against a cycle model at the same time. Directed cases isolate three things that random traffic rarely lines up. The first is an event landing on the clearing read's edge, which separates "clear what was returned" from "clear everything". The second is writes to the status views, which shows they are read-only. The third is holdoff windows started from an active interrupt, which pins down the exact first and last masked cycle and shows the readback bit falling in step with the window.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DATA_W       = 32;
  localparam int N_FIXED_EVT  = 9;
  localparam int CTRL_W       = 9;
  localparam int N_HOLD       = 2;

  localparam logic [3:0] IDX_STAT_CLR  = 4'h1;
  localparam logic [3:0] IDX_STAT_PEEK = 4'h2;
  localparam logic [3:0] IDX_ENABLE    = 4'h3;
  localparam logic [3:0] IDX_MCTRL     = 4'h4;

  localparam int BIT_HOLD_SHORT = 0;
  localparam int BIT_HOLD_LONG  = 1;
  localparam int BIT_TXCH0      = 9;
endpackage

// File: rtl/irq_holdoff_timer.sv
module irq_holdoff_timer #(
  parameter int DUR_CYC = 62500,
  localparam int CW = $clog2(DUR_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic start,
  output logic active
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = start ? CW'(DUR_CYC) : '0;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R8: an idle timer stays idle unless it is loaded
  p_idle_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !active) |=> !active);
  // R12: loading with start low stops the timer
  p_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !start) |=> !active);
endmodule

// File: rtl/irq_pending_bank.sv
module irq_pending_bank #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en
);
  logic [W-1:0] pend_d, en_d;

  always_comb begin
    pend_d = (clr ? '0 : pend) | evt;
    en_d   = en_we ? en_wdata : en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      en   <= '0;
    end else begin
      pend <= pend_d;
      en   <= en_d;
    end
  end

  // R4: every pulsed event is pending on the next cycle
  p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((pend & $past(evt)) == $past(evt)));
  // R1: without a clearing read, no pending bit is lost
  p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((pend & $past(pend)) == $past(pend)));
  // R2: a clearing read with no new event leaves nothing pending
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (pend == '0));
  // R3: a new event survives a clearing read on the same edge
  p_collide_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && |evt) |=> (pend == $past(evt)));
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_pkg::*;
#(
  parameter int ADDR_W         = 4,
  parameter int N_TXCH         = 8,
  parameter int HOLD_SHORT_CYC = 62500,
  parameter int HOLD_LONG_CYC  = 125000,
  localparam int NEVT = N_FIXED_EVT + N_TXCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NEVT-1:0]   evt_pulse,
  output logic              irq_o
);
  logic [3:0] idx;
  logic       sel_clr, sel_peek, sel_en, sel_mc;
  logic       clr, en_we, mc_we;
  logic [NEVT-1:0] pend, en;
  logic [CTRL_W-1:BIT_HOLD_LONG+1] mc_q, mc_d;
  logic [N_HOLD-1:0] hold_act;
  logic       hold_any;

  assign idx      = 4'(reg_addr);
  assign sel_clr  = (idx == IDX_STAT_CLR);
  assign sel_peek = (idx == IDX_STAT_PEEK);
  assign sel_en   = (idx == IDX_ENABLE);
  assign sel_mc   = (idx == IDX_MCTRL);
  assign clr      = reg_rd & sel_clr;
  assign en_we    = reg_wr & sel_en;
  assign mc_we    = reg_wr & sel_mc;

  irq_pending_bank #(.W(NEVT)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .clr      (clr),
    .en_we    (en_we),
    .en_wdata (reg_wdata[NEVT-1:0]),
    .pend     (pend),
    .en       (en)
  );

  for (genvar g = 0; g < N_HOLD; g++) begin : g_hold
    localparam int DUR = (g == BIT_HOLD_SHORT) ? HOLD_SHORT_CYC : HOLD_LONG_CYC;
    irq_holdoff_timer #(.DUR_CYC(DUR)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (mc_we),
      .start  (reg_wdata[g]),
      .active (hold_act[g])
    );
  end

  assign hold_any = |hold_act;

  always_comb begin
    mc_d = mc_q;
    if (mc_we) mc_d = reg_wdata[CTRL_W-1:BIT_HOLD_LONG+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mc_q <= '0;
    else        mc_q <= mc_d;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_clr || sel_peek) reg_rdata[NEVT-1:0] = pend;
      else if (sel_en)         reg_rdata[NEVT-1:0] = en;
      else if (sel_mc)         reg_rdata[CTRL_W-1:0] = {mc_q, hold_act};
    end
  end

  assign irq_o = (|(pend & en)) & ~hold_any;

  // R8: nothing is delivered while a holdoff window runs
  p_hold_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_any |-> !irq_o);
  // R6: an enabled pending bit raises the output outside holdoff
  p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(pend & en)) && !hold_any) |-> irq_o);
  // R5: enable register takes the written bits
  p_en_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> (en == $past(reg_wdata[NEVT-1:0])));
  // R10: writes to status views leave status alone
  p_ro_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (sel_clr || sel_peek) && !clr && evt_pulse == '0) |=> (pend == $past(pend)));
  // R7: control bits hold their value without a control write
  p_mc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_we |=> $stable(mc_q));
endmodule

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  localparam int NEVT = 17;
  localparam int HS   = 20;
  localparam int HL   = 45;

  logic clk = 0;
  logic rst_n;
  logic reg_wr, reg_rd;
  logic [3:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [NEVT-1:0] evt_pulse;
  logic irq_o;

  int checks = 0;
  int fails  = 0;

  logic [NEVT-1:0] m_pend, m_en;
  logic [8:2] m_mc;
  int m_cs, m_cl;

  always #4 clk = ~clk;

  irq_status_ctrl #(.ADDR_W(4), .N_TXCH(8), .HOLD_SHORT_CYC(HS), .HOLD_LONG_CYC(HL)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h1, 4'h2: return 32'(m_pend);
      4'h3:       return 32'(m_en);
      4'h4:       return {23'd0, m_mc, (m_cl != 0), (m_cs != 0)};
      default:    return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (|(m_pend & m_en)) && m_cs == 0 && m_cl == 0;
  endfunction

  function automatic string rd_tag(input logic [3:0] a);
    case (a)
      4'h1: return "R2";
      4'h2: return "R1";
      4'h3: return "R5";
      4'h4: return "R7";
      default: return "R12";
    endcase
  endfunction

  // one clock: drive at negedge, check before posedge, update model after it
  task automatic step(input bit w, input bit r, input logic [3:0] a,
                      input logic [31:0] d, input logic [NEVT-1:0] e);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; evt_pulse = e;
    #2;
    if (r) chk(rd_tag(a), reg_rdata, exp_read(a));
    chk((m_cs != 0 || m_cl != 0) ? "R8" : "R6", 32'(irq_o), 32'(exp_irq()));
    @(posedge clk);
    m_pend = ((r && a == 4'h1) ? '0 : m_pend) | e;
    if (w && a == 4'h3) m_en = d[NEVT-1:0];
    if (w && a == 4'h4) begin
      m_mc = d[8:2];
      m_cs = d[0] ? HS : 0;
      m_cl = d[1] ? HL : 0;
    end else begin
      if (m_cs != 0) m_cs--;
      if (m_cl != 0) m_cl--;
    end
  endtask

  task automatic idle(); step(0, 0, 4'h0, 32'd0, '0); endtask

  task automatic rd_now(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_wr = 0; reg_rd = 1; reg_addr = a; reg_wdata = 0; evt_pulse = '0;
    #2 v = reg_rdata;
    @(posedge clk);
    if (a == 4'h1) m_pend = '0;
    if (m_cs != 0) m_cs--;
    if (m_cl != 0) m_cl--;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240607));
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0; evt_pulse = '0;
    m_pend = '0; m_en = '0; m_mc = '0; m_cs = 0; m_cl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R11 reset state
    chk("R11", 32'(irq_o), 32'd0);
    rd_now(4'h2, v); chk("R11", v, 32'd0);
    rd_now(4'h3, v); chk("R11", v, 32'd0);
    rd_now(4'h4, v); chk("R11", v, 32'd0);

    // R4 layout, R1 non-clearing view
    step(0, 0, 4'h0, 0, 17'(1 << 3));
    rd_now(4'h2, v); chk("R4", v, 32'h8);
    rd_now(4'h2, v); chk("R1", v, 32'h8);
    // R2 clearing view
    rd_now(4'h1, v); chk("R2", v, 32'h8);
    rd_now(4'h2, v); chk("R2", v, 32'h0);

    // R3 collision: bit 0 pending, tx channel 7 (bit 16) arrives on the clearing read
    step(0, 0, 4'h0, 0, 17'h1);
    @(negedge clk);
    reg_wr = 0; reg_rd = 1; reg_addr = 4'h1; evt_pulse = 17'h10000;
    #2 chk("R3", reg_rdata, 32'h1);
    @(posedge clk); m_pend = 17'h10000;
    rd_now(4'h2, v); chk("R3", v, 32'h10000);

    // R5 enable readback, R6 interrupt
    step(1, 0, 4'h3, 32'hFFFF_FFFF, '0);
    rd_now(4'h3, v); chk("R5", v, 32'h1FFFF);
    #1 chk("R6", 32'(irq_o), 32'd1);
    step(1, 0, 4'h3, 32'h0000_FFFF, '0);
    #1 chk("R6", 32'(irq_o), 32'd0);
    step(1, 0, 4'h3, 32'h0001_0000, '0);

    // R10 writes to status views ignored
    step(1, 0, 4'h1, 32'hFFFF_FFFF, '0);
    step(1, 0, 4'h2, 32'h0000_0000, '0);
    rd_now(4'h2, v); chk("R10", v, 32'h10000);
    rd_now(4'h3, v); chk("R10", v, 32'h10000);

    // R7 control readback; R12 unmapped index
    step(1, 0, 4'h4, 32'hFFFF_FFFC, '0);
    rd_now(4'h4, v); chk("R7", v, 32'h1FC);
    rd_now(4'h7, v); chk("R12", v, 32'h0);

    // R8 short holdoff: masked for HS cycles after the write edge
    step(1, 0, 4'h4, 32'h0000_0015, '0);
    rd_now(4'h4, v); chk("R8", v, 32'h15);
    for (int i = 0; i < HS - 2; i++) idle();
    #1 chk("R8", 32'(irq_o), 32'd0);
    idle();
    #1 chk("R8", 32'(irq_o), 32'd1);
    rd_now(4'h4, v); chk("R8", v, 32'h14);

    // R9 long holdoff, then R12 stop by writing 0
    step(1, 0, 4'h4, 32'h0000_0002, '0);
    for (int i = 0; i < HS + 5; i++) idle();
    rd_now(4'h4, v); chk("R9", v, 32'h2);
    #1 chk("R9", 32'(irq_o), 32'd0);
    step(1, 0, 4'h4, 32'h0, '0);
    #1 chk("R12", 32'(irq_o), 32'd1);
    rd_now(4'h1, v); chk("R2", v, 32'h10000);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom_range(0, 9);
      logic [3:0] a = 4'($urandom_range(0, 6));
      logic [31:0] d = $urandom;
      logic [NEVT-1:0] e = NEVT'($urandom & $urandom & $urandom);
      if (a == 4'h4 && $urandom_range(0, 7) != 0) d[1:0] = 2'b00;
      if (op < 4)      step(0, 1, a, 0, e);
      else if (op < 6) step(1, 0, a, d, e);
      else             step(0, 0, a, 0, e);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule